// File: doc/BRIEF.md
# Prefixed Shift Execution Unit

This unit carries out the three single-bit shift instructions of an 8-bit processor that sit behind the prefix byte: arithmetic shift left, arithmetic shift right (sign kept) and logical shift right. The core pulses `start_i` with the second opcode byte and presents its general registers. The unit works out which operand is meant, shifts it and produces the new flag byte. It then hands back either a register write-back (destination code plus data) or carries out a read-modify-write of the byte at the address held in the H:L pair.

A register operand is finished in the cycle after the start. A memory operand goes through a request/ready port: first a read, then a write of the shifted byte to the same address. The unit reports the instruction's nominal machine-cycle cost so the core can account for time. Opcodes outside the three shift groups are refused without side effects.

Top module: `shift_exec_unit`

## Requirements
- R1: Opcode bits [7:3] select the operation: 5'b00100 (0x20–0x27) is arithmetic left, 5'b00101 (0x28–0x2F) is arithmetic right, 5'b00111 (0x38–0x3F) is logical right. Any other value is illegal.
- R2: Opcode bits [2:0] select the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory byte at address {H,L}, 7 A. A register result is written back to the same code on `reg_sel_o`, and a register operation issues no memory request.
- R3: Arithmetic left: the result is the operand shifted left by one with bit 0 filled with 0, kept to 8 bits. Carry takes operand bit 7.
- R4: Arithmetic right: the result is the operand shifted right by one with bit 7 unchanged. Carry takes operand bit 0.
- R5: Logical right: the result is the operand shifted right by one with bit 7 forced to 0. Carry takes operand bit 0.
- R6: The flag byte is laid out as {Z,N,H,C,4'b0000}, with Z at bit 7 and C at bit 4. Z is set exactly when the 8-bit result is zero, and N and H are 0. Carry comes from the shifted operand and never from A. `flag_we_o` is high with `done_o` for every legal opcode.
- R7: A register operation raises `done_o`, `reg_we_o` and `flag_we_o` in the cycle right after the start cycle, with `cycles_o` = 8.
- R8: A memory operation first reads address {H,L} (`mem_we_o`=0). After that read is accepted, it writes the shifted byte to the same address (`mem_we_o`=1). `done_o` rises in the cycle after the write is accepted, with `cycles_o` = 16 and `reg_we_o` low.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the address, write enable and write data stay unchanged in the next cycle.
- R10: An illegal opcode gives `done_o` and `illegal_o` in the cycle after start, with `reg_we_o`, `flag_we_o` and `mem_req_o` low and `cycles_o` = 0.
- R11: `start_i` is only taken while the unit is idle. Strobes during an operation or during its `done_o` cycle are ignored.
- R12: `done_o` lasts exactly one cycle. After reset `done_o`, `mem_req_o`, `reg_we_o` and `flag_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| opcode_i | input | 8 | Second opcode byte, valid with start |
| reg_b_i | input | 8 | Register B |
| reg_c_i | input | 8 | Register C |
| reg_d_i | input | 8 | Register D |
| reg_e_i | input | 8 | Register E |
| reg_h_i | input | 8 | Register H (address high byte) |
| reg_l_i | input | 8 | Register L (address low byte) |
| reg_a_i | input | 8 | Register A |
| mem_rdata_i | input | 8 | Memory read data, valid with ready on a read |
| mem_ready_i | input | 1 | Memory accepts or completes the current request |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory address {H,L} |
| mem_wdata_o | output | 8 | Shifted byte to write |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Opcode not a supported shift, with done |
| reg_we_o | output | 1 | Register write-back strobe, with done |
| reg_sel_o | output | 3 | Destination register code |
| result_o | output | 8 | Shifted byte |
| flag_we_o | output | 1 | Flag update strobe, with done |
| flags_o | output | 8 | New flag byte {Z,N,H,C,0000} |
| cycles_o | output | 5 | Nominal cycle cost (8, 16, or 0 if illegal) |

## Verification
The properties assume that `mem_ready_i` is only raised while a request is pending and drops right after the accepting edge. They also assume that read data is valid in the same cycle as ready. Under those conditions, the fixed read-then-write order and the held request fields can be checked purely from the port sequence. The bench's memory responder follows these rules: it asserts ready for exactly one cycle after a latency of 0 to 2 cycles and never without a request. The opcode is changed only between starts, or while the unit is busy in the test that shows busy-time strobes are ignored.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [1:0] {SK_SLA, SK_SRA, SK_SRL, SK_NONE} shift_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} seq_state_e;
  localparam logic [2:0] SEL_MEM = 3'd6;
  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_unit_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode,
  output shift_kind_e      kind,
  output logic [2:0]       sel,
  output logic             is_mem
);
  localparam int GRP_W = OPC_W - 3;

  logic [GRP_W-1:0] group;
  assign group  = opcode[OPC_W-1:3];
  assign sel    = opcode[2:0];
  assign is_mem = (opcode[2:0] == SEL_MEM);

  always_comb begin
    case (group)
      GRP_W'(4): kind = SK_SLA;
      GRP_W'(5): kind = SK_SRA;
      GRP_W'(7): kind = SK_SRL;
      default:   kind = SK_NONE;
    endcase
  end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  shift_kind_e       kind,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags
);
  logic carry;

  always_comb begin
    case (kind)
      SK_SLA: begin
        result = {operand[DATA_W-2:0], 1'b0};
        carry  = operand[DATA_W-1];
      end
      SK_SRA: begin
        result = {operand[DATA_W-1], operand[DATA_W-1:1]};
        carry  = operand[0];
      end
      SK_SRL: begin
        result = {1'b0, operand[DATA_W-1:1]};
        carry  = operand[0];
      end
      default: begin
        result = operand;
        carry  = 1'b0;
      end
    endcase
    flags         = '0;
    flags[FLAG_Z] = (result == '0);
    flags[FLAG_N] = 1'b0;
    flags[FLAG_H] = 1'b0;
    flags[FLAG_C] = carry;
  end
endmodule

// File: rtl/shift_seq.sv
module shift_seq
  import shift_unit_pkg::*;
(
  input  seq_state_e state_q,
  input  logic       start_i,
  input  logic       illegal,
  input  logic       is_mem,
  input  logic       mem_ready_i,
  output seq_state_e state_d,
  output logic       ctx_en,
  output logic       res_en
);
  always_comb begin
    state_d = state_q;
    ctx_en  = 1'b0;
    res_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctx_en = 1'b1;
          if (illegal) begin
            state_d = ST_FIN;
          end else if (is_mem) begin
            state_d = ST_RD;
          end else begin
            res_en  = 1'b1;
            state_d = ST_FIN;
          end
        end
      end
      ST_RD: begin
        if (mem_ready_i) begin
          res_en  = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (mem_ready_i) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CYC_REG = 8,
  parameter int CYC_MEM = 16,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int CNT_W  = $clog2(CYC_MEM + 1),
  localparam int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] reg_b_i,
  input  logic [DATA_W-1:0] reg_c_i,
  input  logic [DATA_W-1:0] reg_d_i,
  input  logic [DATA_W-1:0] reg_e_i,
  input  logic [DATA_W-1:0] reg_h_i,
  input  logic [DATA_W-1:0] reg_l_i,
  input  logic [DATA_W-1:0] reg_a_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              reg_we_o,
  output logic [2:0]        reg_sel_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_we_o,
  output logic [7:0]        flags_o,
  output logic [CNT_W-1:0]  cycles_o
);
  logic [NREG-1:0][DATA_W-1:0] gpr;
  assign gpr = {reg_a_i, {DATA_W{1'b0}}, reg_l_i, reg_h_i,
                reg_e_i, reg_d_i, reg_c_i, reg_b_i};

  shift_kind_e dec_kind;
  logic [2:0]  dec_sel;
  logic        dec_mem;

  shift_decode #(.OPC_W(8)) u_dec (
    .opcode (opcode_i),
    .kind   (dec_kind),
    .sel    (dec_sel),
    .is_mem (dec_mem)
  );

  seq_state_e        state_q, state_d;
  shift_kind_e       kind_q;
  logic [2:0]        sel_q;
  logic              mem_q, illegal_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] res_q;
  logic [7:0]        flg_q;
  logic              ctx_en, res_en;

  shift_kind_e       alu_kind;
  logic [DATA_W-1:0] alu_in, alu_res;
  logic [7:0]        alu_flags;

  assign alu_kind = (state_q == ST_RD) ? kind_q : dec_kind;
  assign alu_in   = (state_q == ST_RD) ? mem_rdata_i : gpr[dec_sel];

  shift_alu #(.DATA_W(DATA_W)) u_alu (
    .kind    (alu_kind),
    .operand (alu_in),
    .result  (alu_res),
    .flags   (alu_flags)
  );

  shift_seq u_seq (
    .state_q     (state_q),
    .start_i     (start_i),
    .illegal     (dec_kind == SK_NONE),
    .is_mem      (dec_mem),
    .mem_ready_i (mem_ready_i),
    .state_d     (state_d),
    .ctx_en      (ctx_en),
    .res_en      (res_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= SK_NONE;
      sel_q     <= '0;
      mem_q     <= 1'b0;
      illegal_q <= 1'b0;
      addr_q    <= '0;
      res_q     <= '0;
      flg_q     <= '0;
    end else begin
      state_q <= state_d;
      if (ctx_en) begin
        kind_q    <= dec_kind;
        sel_q     <= dec_sel;
        mem_q     <= dec_mem;
        illegal_q <= (dec_kind == SK_NONE);
        addr_q    <= {reg_h_i, reg_l_i};
      end
      if (res_en) begin
        res_q <= alu_res;
        flg_q <= alu_flags;
      end
    end
  end

  assign done_o      = (state_q == ST_FIN);
  assign illegal_o   = done_o && illegal_q;
  assign reg_we_o    = done_o && !illegal_q && !mem_q;
  assign flag_we_o   = done_o && !illegal_q;
  assign reg_sel_o   = sel_q;
  assign result_o    = res_q;
  assign flags_o     = flg_q;
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = res_q;
  assign cycles_o    = (!done_o || illegal_q) ? '0 :
                       (mem_q ? CNT_W'(CYC_MEM) : CNT_W'(CYC_REG));
endmodule

// File: rtl/shift_exec_unit_chk.sv
module shift_exec_unit_chk #(
  parameter int DATA_W  = 8,
  parameter int CYC_REG = 8,
  parameter int CYC_MEM = 16,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ready_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic              reg_we_o,
  input logic              flag_we_o,
  input logic [7:0]        flags_o,
  input logic [DATA_W-1:0] result_o,
  input logic [CNT_W-1:0]  cycles_o
);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_read_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_we_o && mem_ready_i |=> mem_req_o && mem_we_o && $stable(mem_addr_o));

  assert_write_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o && mem_ready_i |=> done_o && !reg_we_o);

  assert_flag_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> flags_o[6:5] == 2'b00 && flags_o[3:0] == 4'h0);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> flags_o[7] == (result_o == '0));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> done_o && !reg_we_o && !flag_we_o && !mem_req_o && cycles_o == '0);

  assert_reg_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> cycles_o == CNT_W'(CYC_REG) && !mem_req_o);

  assert_mem_cost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !illegal_o && !reg_we_o |-> cycles_o == CNT_W'(CYC_MEM));

  assert_idle_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);
endmodule

bind shift_exec_unit shift_exec_unit_chk #(
  .DATA_W(DATA_W), .CYC_REG(CYC_REG), .CYC_MEM(CYC_MEM),
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ready_i(mem_ready_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .done_o(done_o), .illegal_o(illegal_o),
  .reg_we_o(reg_we_o), .flag_we_o(flag_we_o), .flags_o(flags_o),
  .result_o(result_o), .cycles_o(cycles_o)
);

// File: tb/shift_exec_unit_tb.sv
module shift_exec_unit_tb;
  localparam int CLK_P = 10;
  localparam int VEC_N = 15;
  // {opcode, operand, expected result, expected flags}
  localparam logic [31:0] VEC [VEC_N] = '{
    32'h20_81_02_10, 32'h21_80_00_90, 32'h27_40_80_00, 32'h24_FF_FE_10,
    32'h26_C3_86_10, 32'h28_81_C0_10, 32'h2D_01_00_90, 32'h2F_7E_3F_00,
    32'h2A_80_C0_00, 32'h2E_80_C0_00, 32'h38_81_40_10, 32'h3B_01_00_90,
    32'h3F_FE_7F_00, 32'h39_00_00_80, 32'h3E_01_00_90
  };

  logic clk, rst_n, start_i;
  logic [7:0] opcode_i, rb, rc, rd, re, rh, rl, ra;
  logic [7:0] mem_val;
  logic mem_ready;
  logic mem_req, mem_we, done, illegal, reg_we, flag_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, result, flags;
  logic [2:0] reg_sel;
  logic [4:0] cycles;

  int n_chk = 0;
  int n_err = 0;
  int lat = 0;
  int cnt = 0;
  int wr_cnt = 0;
  int req_cycles = 0;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0] wr_data;

  shift_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .reg_b_i(rb), .reg_c_i(rc), .reg_d_i(rd), .reg_e_i(re),
    .reg_h_i(rh), .reg_l_i(rl), .reg_a_i(ra),
    .mem_rdata_i(mem_val), .mem_ready_i(mem_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .done_o(done), .illegal_o(illegal),
    .reg_we_o(reg_we), .reg_sel_o(reg_sel), .result_o(result),
    .flag_we_o(flag_we), .flags_o(flags), .cycles_o(cycles)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // memory responder: one-cycle ready after lat waiting cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      cnt <= 0;
    end else begin
      if (mem_req) req_cycles <= req_cycles + 1;
      if (mem_ready) begin
        mem_ready <= 1'b0;
        cnt <= 0;
        if (mem_we) begin
          wr_cnt  <= wr_cnt + 1;
          wr_addr <= mem_addr;
          wr_data <= mem_wdata;
        end else begin
          rd_addr <= mem_addr;
        end
      end else if (mem_req) begin
        if (cnt >= lat) mem_ready <= 1'b1;
        else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  function automatic string ktag(input logic [7:0] o);
    case (o[5:3])
      3'd4:    return "R3";
      3'd5:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] opc, output int n);
    @(negedge clk);
    opcode_i = opc;
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_err++;
    $display("FAIL R12 watchdog act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n;
    int w0, q0, dn;
    logic [7:0] opc, opnd, eres, eflg;
    rst_n = 1'b0; start_i = 1'b0; opcode_i = 8'h00;
    rb = 8'h5A; rc = 8'h5A; rd = 8'h5A; re = 8'h5A;
    rh = 8'h12; rl = 8'h34; ra = 8'h5A; mem_val = 8'h00;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!done && !mem_req && !reg_we && !flag_we, "R12 reset outputs",
        {12'h0, done, mem_req, reg_we, flag_we}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < VEC_N; i++) begin
      {opc, opnd, eres, eflg} = VEC[i];
      rb = 8'h5A; rc = 8'h5A; rd = 8'h5A; re = 8'h5A;
      rh = 8'h12; rl = 8'h34; ra = 8'h5A;
      lat = i % 3;
      case (opc[2:0])
        3'd0: rb = opnd;
        3'd1: rc = opnd;
        3'd2: rd = opnd;
        3'd3: re = opnd;
        3'd4: rh = opnd;
        3'd5: rl = opnd;
        3'd6: mem_val = opnd;
        default: ra = opnd;
      endcase
      w0 = wr_cnt;
      q0 = req_cycles;
      run_op(opc, n);
      chk(done && !illegal, "R1 decoded as legal", {14'h0, done, illegal}, 16'h2);
      chk(result == eres, ktag(opc), {8'h0, result}, {8'h0, eres});
      chk(flags == eflg && flag_we, "R6 flags", {7'h0, flag_we, flags}, {8'h1, eflg});
      if (opc[2:0] != 3'd6) begin
        chk(n == 1, "R7 latency", 16'(n), 16'd1);
        chk(reg_we && cycles == 5'd8, "R7 write-back and cost",
            {10'h0, reg_we, cycles}, {10'h0, 1'b1, 5'd8});
        chk(reg_sel == opc[2:0], "R2 destination", {13'h0, reg_sel}, {13'h0, opc[2:0]});
        chk(wr_cnt == w0 && req_cycles == q0, "R2 no memory access",
            16'(req_cycles - q0), 16'd0);
      end else begin
        chk(!reg_we && cycles == 5'd16, "R8 no write-back, cost",
            {10'h0, reg_we, cycles}, {10'h0, 1'b0, 5'd16});
        chk(wr_cnt == w0 + 1 && wr_data == eres, "R8 written byte",
            {8'h0, wr_data}, {8'h0, eres});
        chk(rd_addr == 16'h1234 && wr_addr == 16'h1234, "R8 address", wr_addr, 16'h1234);
      end
      @(negedge clk);
      chk(!done, "R12 single-cycle done", {15'h0, done}, 16'h0);
    end

    // R10 illegal opcodes, including memory-encoded and neighbouring groups
    lat = 0;
    foreach (VEC[k]) begin
      if (k < 5) begin
        case (k)
          0: opc = 8'h30;
          1: opc = 8'h00;
          2: opc = 8'h1E;
          3: opc = 8'h40;
          default: opc = 8'h36;
        endcase
        w0 = wr_cnt;
        q0 = req_cycles;
        run_op(opc, n);
        chk(n == 1 && illegal, "R10 illegal flagged", {15'h0, illegal}, 16'h1);
        chk(!reg_we && !flag_we && cycles == 5'd0, "R10 no update",
            {9'h0, reg_we, flag_we, cycles}, 16'h0);
        chk(req_cycles == q0 && wr_cnt == w0, "R10 no memory", 16'(req_cycles - q0), 16'd0);
      end
    end

    // R11 start held through a memory operation and its done cycle
    lat = 2;
    rh = 8'hAB; rl = 8'hCD; mem_val = 8'h81; rb = 8'h00;
    w0 = wr_cnt;
    @(negedge clk);
    opcode_i = 8'h2E;
    start_i = 1'b1;
    @(negedge clk);
    opcode_i = 8'h20;
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(result == 8'hC0 && flags == 8'h10, "R11 first op result", {8'h0, result}, 16'h00C0);
    @(negedge clk);
    start_i = 1'b0;
    dn = 0;
    for (int j = 0; j < 4; j++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk(dn == 0, "R11 busy strobes ignored", 16'(dn), 16'd0);
    chk(wr_cnt == w0 + 1 && wr_addr == 16'hABCD, "R11 one write only", wr_addr, 16'hABCD);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule